// File: doc/BRIEF.md
# Commit-to-Architectural Register Transfer

This block sits between a speculative commit register file and the architectural register file of an out-of-order core. Each commit entry carries a three-valued state: free (its result, if any, now lives in the architectural file), pending (allocated, result not produced yet) or done (result written by an execution unit and held in the commit file). Execution units write only into the commit file. Retirement copies results into the architectural file and frees the entries.

Every clock the block takes a batch of up to `NLANE` retiring entries, each with its destination architectural register. Lanes are in program order, with lane 0 the oldest. When the batch names one destination more than once, the block keeps only the youngest valid lane's write. As a result no two architectural write ports are ever enabled with the same address. Lookup ports tell the scheduler where an operand lives: not ready, in the commit file, or in the architectural file. They also return the operand value. A flush input drops every in-flight entry back to free and leaves the architectural contents untouched.

Top module: `xfer_commit_retire`

## Requirements
- R1: After reset every commit entry is free, every architectural register reads 0, and all architectural write enables are low.
- R2: An allocated entry becomes pending on the next clock. A lookup of a live source on a pending entry reports code 0 (not ready) with data 0.
- R3: An execution write to an entry makes it done on the next clock. A live lookup then reports code 1 (commit file) and returns the written value.
- R4: A retiring lane's entry becomes free on the next clock, and its value is written into the architectural register named by the lane. A live lookup of a free entry reports code 2 (architectural file) and returns the architectural register given in the lookup.
- R5: When several valid lanes of one batch share a destination, only the highest-indexed of them drives its write enable. The suppressed lanes still free their entries.
- R6: No two architectural write ports are enabled with equal addresses in the same clock.
- R7: A valid lane with no younger duplicate drives its write enable, with address equal to its destination and data equal to its entry's commit value, in the same clock it is presented.
- R8: While flush is high, all write enables are low and retirement, execution writes and allocation are ignored. On the next clock every entry is free, and the architectural registers are unchanged.
- R9: A lookup whose source is not live reports code 2 and returns the named architectural register.
- R10: A lane whose valid bit is low neither writes nor suppresses an older valid lane, even when it carries the same destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop all in-flight entries this clock |
| alloc_en | input | 1 | Mark an entry pending |
| alloc_idx | input | CIW | Entry to allocate |
| wb_en | input | NWB | Execution write enables |
| wb_idx | input | NWB*CIW | Entry written by each execution port |
| wb_data | input | NWB*XW | Result of each execution port |
| ret_valid | input | NLANE | Valid bits of the retiring batch, lane 0 oldest |
| ret_idx | input | NLANE*CIW | Commit entry of each lane |
| ret_dst | input | NLANE*AW | Destination architectural register of each lane |
| lk_live | input | NLK | Source is still mapped to a commit entry |
| lk_idx | input | NLK*CIW | Commit entry of the source |
| lk_areg | input | NLK*AW | Architectural register of the source |
| lk_src | output | NLK*2 | 0 not ready, 1 commit file, 2 architectural file |
| lk_data | output | NLK*XW | Operand value |
| aw_en | output | NLANE | Architectural write enables after filtering |
| aw_addr | output | NLANE*AW | Architectural write addresses |
| aw_data | output | NLANE*XW | Architectural write data |

## Verification
The batch filter is tried with a full batch of distinct destinations, which shows that nothing is dropped without cause. It is also tried with an all-equal batch and with interleaved pairs, which separate keeping the youngest lane from keeping the oldest. Sparse valid masks, with an invalid lane sharing a destination, show whether invalid lanes take part in the comparison, and an empty batch shows that nothing is written spuriously. After each batch the architectural contents are read back through lookups and compared with a model that applies the writes in program order. A flush that arrives together with a retiring lane shows that flush takes precedence over retirement.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    ENT_FREE = 2'd0,
    ENT_PEND = 2'd1,
    ENT_DONE = 2'd2
  } ent_t;

  typedef enum logic [1:0] {
    SRC_WAIT   = 2'd0,
    SRC_COMMIT = 2'd1,
    SRC_ARCH   = 2'd2
  } src_t;
endpackage

// File: rtl/xfer_entry_table.sv
module xfer_entry_table
  import xfer_pkg::*;
#(
  parameter int NENT  = 16,
  parameter int XW    = 32,
  parameter int NLANE = 4,
  parameter int NWB   = 2,
  localparam int CIW  = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          alloc_go,
  input  logic [CIW-1:0]                alloc_idx,
  input  logic [NWB-1:0]                wb_go,
  input  logic [NWB-1:0][CIW-1:0]       wb_idx,
  input  logic [NWB-1:0][XW-1:0]        wb_data,
  input  logic [NLANE-1:0]              ret_go,
  input  logic [NLANE-1:0][CIW-1:0]     ret_idx,
  output ent_t [NENT-1:0]               state,
  output logic [NENT-1:0][XW-1:0]       cdata
);
  logic [NENT-1:0]          hit_alloc;
  logic [NENT-1:0]          hit_wb;
  logic [NENT-1:0]          hit_ret;
  logic [NENT-1:0][XW-1:0]  wb_val;

  always_comb begin
    for (int e = 0; e < NENT; e++) begin
      hit_alloc[e] = alloc_go && (alloc_idx == CIW'(e));
      hit_wb[e]    = 1'b0;
      hit_ret[e]   = 1'b0;
      wb_val[e]    = '0;
      for (int p = 0; p < NWB; p++) begin
        if (wb_go[p] && (wb_idx[p] == CIW'(e))) begin
          hit_wb[e] = 1'b1;
          wb_val[e] = wb_data[p];
        end
      end
      for (int l = 0; l < NLANE; l++) begin
        if (ret_go[l] && (ret_idx[l] == CIW'(e))) hit_ret[e] = 1'b1;
      end
    end
  end

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        state[e] <= ENT_FREE;
      end else if (flush) begin
        state[e] <= ENT_FREE;
      end else if (hit_ret[e]) begin
        state[e] <= ENT_FREE;
      end else if (hit_wb[e]) begin
        state[e] <= ENT_DONE;
      end else if (hit_alloc[e]) begin
        state[e] <= ENT_PEND;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cdata[e] <= '0;
      end else if (hit_wb[e] && !flush) begin
        cdata[e] <= wb_val[e];
      end
    end
  end
endmodule

// File: rtl/xfer_dup_filter.sv
module xfer_dup_filter #(
  parameter int NLANE = 4,
  parameter int AW    = 5
) (
  input  logic                      flush,
  input  logic [NLANE-1:0]          ret_valid,
  input  logic [NLANE-1:0][AW-1:0]  ret_dst,
  output logic [NLANE-1:0]          keep
);
  // A lane is shadowed when any younger valid lane names the same register.
  function automatic logic younger_clash(
    input logic [NLANE-1:0]          v,
    input logic [NLANE-1:0][AW-1:0]  d,
    input int                        lane
  );
    logic hit;
    hit = 1'b0;
    for (int k = 0; k < NLANE; k++) begin
      if ((k > lane) && v[k] && (d[k] == d[lane])) hit = 1'b1;
    end
    return hit;
  endfunction

  logic [NLANE-1:0] shadowed;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign shadowed[l] = younger_clash(ret_valid, ret_dst, l);
    assign keep[l]     = ret_valid[l] && !shadowed[l] && !flush;
  end
endmodule

// File: rtl/xfer_arch_file.sv
module xfer_arch_file #(
  parameter int NARCH = 32,
  parameter int XW    = 32,
  parameter int NLANE = 4,
  localparam int AW   = (NARCH > 1) ? $clog2(NARCH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NLANE-1:0]          we,
  input  logic [NLANE-1:0][AW-1:0]  waddr,
  input  logic [NLANE-1:0][XW-1:0]  wdata,
  output logic [NARCH-1:0][XW-1:0]  regs
);
  for (genvar r = 0; r < NARCH; r++) begin : g_reg
    logic          hit;
    logic [XW-1:0] val;
    always_comb begin
      hit = 1'b0;
      val = '0;
      for (int l = 0; l < NLANE; l++) begin
        if (we[l] && (waddr[l] == AW'(r))) begin
          hit = 1'b1;
          val = wdata[l];
        end
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n)   regs[r] <= '0;
      else if (hit) regs[r] <= val;
    end
  end
endmodule

// File: rtl/xfer_src_lookup.sv
module xfer_src_lookup
  import xfer_pkg::*;
#(
  parameter int NENT  = 16,
  parameter int NARCH = 32,
  parameter int XW    = 32,
  parameter int NLK   = 2,
  localparam int CIW  = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int AW   = (NARCH > 1) ? $clog2(NARCH) : 1
) (
  input  ent_t [NENT-1:0]           state,
  input  logic [NENT-1:0][XW-1:0]   cdata,
  input  logic [NARCH-1:0][XW-1:0]  regs,
  input  logic [NLK-1:0]            live,
  input  logic [NLK-1:0][CIW-1:0]   idx,
  input  logic [NLK-1:0][AW-1:0]    areg,
  output logic [NLK-1:0][1:0]       src,
  output logic [NLK-1:0][XW-1:0]    data
);
  for (genvar p = 0; p < NLK; p++) begin : g_port
    always_comb begin
      src[p]  = SRC_ARCH;
      data[p] = regs[areg[p]];
      if (live[p]) begin
        unique case (state[idx[p]])
          ENT_PEND: begin
            src[p]  = SRC_WAIT;
            data[p] = '0;
          end
          ENT_DONE: begin
            src[p]  = SRC_COMMIT;
            data[p] = cdata[idx[p]];
          end
          default: begin
            src[p]  = SRC_ARCH;
            data[p] = regs[areg[p]];
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/xfer_commit_retire.sv
module xfer_commit_retire
  import xfer_pkg::*;
#(
  parameter int NENT  = 16,
  parameter int NARCH = 32,
  parameter int XW    = 32,
  parameter int NLANE = 4,
  parameter int NWB   = 2,
  parameter int NLK   = 2,
  localparam int CIW  = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int AW   = (NARCH > 1) ? $clog2(NARCH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      alloc_en,
  input  logic [CIW-1:0]            alloc_idx,
  input  logic [NWB-1:0]            wb_en,
  input  logic [NWB-1:0][CIW-1:0]   wb_idx,
  input  logic [NWB-1:0][XW-1:0]    wb_data,
  input  logic [NLANE-1:0]          ret_valid,
  input  logic [NLANE-1:0][CIW-1:0] ret_idx,
  input  logic [NLANE-1:0][AW-1:0]  ret_dst,
  input  logic [NLK-1:0]            lk_live,
  input  logic [NLK-1:0][CIW-1:0]   lk_idx,
  input  logic [NLK-1:0][AW-1:0]    lk_areg,
  output logic [NLK-1:0][1:0]       lk_src,
  output logic [NLK-1:0][XW-1:0]    lk_data,
  output logic [NLANE-1:0]          aw_en,
  output logic [NLANE-1:0][AW-1:0]  aw_addr,
  output logic [NLANE-1:0][XW-1:0]  aw_data
);
  // Named internal events, visible to the bound checker.
  ent_t [NENT-1:0]           ent_state;
  logic [NENT-1:0][XW-1:0]   ent_data;
  logic [NARCH-1:0][XW-1:0]  arch_regs;
  logic                      alloc_go;
  logic [NWB-1:0]            wb_go;
  logic [NLANE-1:0]          ret_go;
  logic [NLANE-1:0]          lane_keep;

  assign alloc_go = alloc_en && !flush;
  assign wb_go    = wb_en & {NWB{~flush}};
  assign ret_go   = ret_valid & {NLANE{~flush}};

  xfer_entry_table #(
    .NENT(NENT), .XW(XW), .NLANE(NLANE), .NWB(NWB)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_go(alloc_go), .alloc_idx(alloc_idx),
    .wb_go(wb_go), .wb_idx(wb_idx), .wb_data(wb_data),
    .ret_go(ret_go), .ret_idx(ret_idx),
    .state(ent_state), .cdata(ent_data)
  );

  xfer_dup_filter #(.NLANE(NLANE), .AW(AW)) u_filter (
    .flush(flush), .ret_valid(ret_valid), .ret_dst(ret_dst), .keep(lane_keep)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_wport
    assign aw_en[l]   = lane_keep[l];
    assign aw_addr[l] = ret_dst[l];
    assign aw_data[l] = ent_data[ret_idx[l]];
  end

  xfer_arch_file #(.NARCH(NARCH), .XW(XW), .NLANE(NLANE)) u_arch (
    .clk(clk), .rst_n(rst_n), .we(aw_en), .waddr(aw_addr), .wdata(aw_data),
    .regs(arch_regs)
  );

  xfer_src_lookup #(.NENT(NENT), .NARCH(NARCH), .XW(XW), .NLK(NLK)) u_look (
    .state(ent_state), .cdata(ent_data), .regs(arch_regs),
    .live(lk_live), .idx(lk_idx), .areg(lk_areg),
    .src(lk_src), .data(lk_data)
  );
endmodule

// File: rtl/xfer_commit_retire_chk.sv
module xfer_commit_retire_chk
  import xfer_pkg::*;
#(
  parameter int NENT  = 16,
  parameter int NLANE = 4,
  parameter int NWB   = 2,
  parameter int CIW   = 4,
  parameter int AW    = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      flush,
  input logic                      alloc_en,
  input logic [CIW-1:0]            alloc_idx,
  input logic [NWB-1:0]            wb_en,
  input logic [NWB-1:0][CIW-1:0]   wb_idx,
  input logic [NLANE-1:0]          ret_valid,
  input logic [NLANE-1:0][CIW-1:0] ret_idx,
  input logic [NLANE-1:0][AW-1:0]  ret_dst,
  input logic [NLANE-1:0]          aw_en,
  input logic [NLANE-1:0][AW-1:0]  aw_addr,
  input ent_t [NENT-1:0]           ent_state
);
  logic any_busy;
  always_comb begin
    any_busy = 1'b0;
    for (int e = 0; e < NENT; e++) begin
      if (ent_state[e] != ENT_FREE) any_busy = 1'b1;
    end
  end

  assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (aw_en == '0));
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !any_busy);
  assert_alloc_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !flush) |=> (ent_state[$past(alloc_idx)] == ENT_PEND));
  assert_top_lane_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid[NLANE-1] && !flush) |-> aw_en[NLANE-1]);

  for (genvar p = 0; p < NWB; p++) begin : g_wb
    assert_wb_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en[p] && !flush) |=> (ent_state[$past(wb_idx[p])] == ENT_DONE));
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assert_en_needs_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      aw_en[l] |-> ret_valid[l]);
    assert_addr_is_dst_R7: assert property (@(posedge clk) disable iff (!rst_n)
      aw_en[l] |-> (aw_addr[l] == ret_dst[l]));
    assert_retire_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid[l] && !flush) |=> (ent_state[$past(ret_idx[l])] == ENT_FREE));
    for (genvar m = l + 1; m < NLANE; m++) begin : g_pair
      assert_unique_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_en[l] && aw_en[m]) |-> (aw_addr[l] != aw_addr[m]));
    end
  end
endmodule

bind xfer_commit_retire xfer_commit_retire_chk #(
  .NENT(NENT), .NLANE(NLANE), .NWB(NWB), .CIW(CIW), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .alloc_en(alloc_en), .alloc_idx(alloc_idx),
  .wb_en(wb_en), .wb_idx(wb_idx),
  .ret_valid(ret_valid), .ret_idx(ret_idx), .ret_dst(ret_dst),
  .aw_en(aw_en), .aw_addr(aw_addr), .ent_state(ent_state)
);

// File: tb/sim_xfer_commit_retire.sv
`timescale 1ns/1ps
module sim_xfer_commit_retire;
  localparam int NENT = 16, NARCH = 32, XW = 32, NLANE = 4, NWB = 2, NLK = 2;
  localparam int CIW = 4, AW = 5;
  localparam int NVEC = 10;
  // {expected enables, valid mask, dst lane3, lane2, lane1, lane0}
  localparam logic [27:0] VEC [NVEC] = '{
    {4'b1111, 4'b1111, 5'd4,  5'd3,  5'd2,  5'd1 },
    {4'b1000, 4'b1111, 5'd5,  5'd5,  5'd5,  5'd5 },
    {4'b1100, 4'b1111, 5'd7,  5'd6,  5'd7,  5'd6 },
    {4'b0110, 4'b0111, 5'd9,  5'd8,  5'd9,  5'd8 },
    {4'b0100, 4'b0101, 5'd12, 5'd10, 5'd11, 5'd10},
    {4'b1000, 4'b1010, 5'd13, 5'd14, 5'd13, 5'd13},
    {4'b0001, 4'b0001, 5'd0,  5'd0,  5'd0,  5'd15},
    {4'b1000, 4'b1001, 5'd16, 5'd0,  5'd0,  5'd16},
    {4'b0000, 4'b0000, 5'd1,  5'd1,  5'd1,  5'd1 },
    {4'b1110, 4'b1111, 5'd22, 5'd24, 5'd23, 5'd22}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic alloc_en = 1'b0;
  logic [CIW-1:0] alloc_idx = '0;
  logic [NWB-1:0] wb_en = '0;
  logic [NWB-1:0][CIW-1:0] wb_idx = '0;
  logic [NWB-1:0][XW-1:0] wb_data = '0;
  logic [NLANE-1:0] ret_valid = '0;
  logic [NLANE-1:0][CIW-1:0] ret_idx = '0;
  logic [NLANE-1:0][AW-1:0] ret_dst = '0;
  logic [NLK-1:0] lk_live = '0;
  logic [NLK-1:0][CIW-1:0] lk_idx = '0;
  logic [NLK-1:0][AW-1:0] lk_areg = '0;
  logic [NLK-1:0][1:0] lk_src;
  logic [NLK-1:0][XW-1:0] lk_data;
  logic [NLANE-1:0] aw_en;
  logic [NLANE-1:0][AW-1:0] aw_addr;
  logic [NLANE-1:0][XW-1:0] aw_data;

  int checks = 0;
  int errors = 0;
  logic [XW-1:0] arch_m [NARCH];

  always #10 clk = ~clk;

  xfer_commit_retire u0 (.*);

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic look(input logic live, input logic [CIW-1:0] idx, input logic [AW-1:0] areg);
    lk_live[0] = live;
    lk_idx[0]  = idx;
    lk_areg[0] = areg;
    #1;
  endtask

  function automatic logic [XW-1:0] val_of(input int v, input int l);
    return 32'hA000_0000 | (v << 8) | l;
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int r = 0; r < NARCH; r++) arch_m[r] = '0;
    tick();
    tick();
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(aw_en == '0, "R1 enables low", 64'(aw_en), 0);
    for (int e = 0; e < NENT; e += 5) begin
      look(1'b1, CIW'(e), AW'(e + 3));
      chk(lk_src[0] == 2'd2 && lk_data[0] == '0, "R1 entry free, arch zero",
          {lk_src[0], lk_data[0]}, {2'd2, 32'd0});
    end
    // R9: non-live source always comes from the architectural file
    look(1'b0, 4'd0, 5'd9);
    chk(lk_src[0] == 2'd2, "R9 non-live source", 64'(lk_src[0]), 2);

    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] exp_en, vmask;
      int base;
      exp_en = VEC[v][27:24];
      vmask  = VEC[v][23:20];
      base   = (v % 4) * 4;
      // allocate valid lanes
      for (int l = 0; l < NLANE; l++) begin
        if (vmask[l]) begin
          alloc_en = 1'b1;
          alloc_idx = CIW'(base + l);
          tick();
        end
      end
      alloc_en = 1'b0;
      if (vmask != 0) begin
        for (int l = 0; l < NLANE; l++) begin
          if (vmask[l]) begin
            look(1'b1, CIW'(base + l), 5'd0);
            chk(lk_src[0] == 2'd0 && lk_data[0] == '0, "R2 pending not ready",
                {lk_src[0], lk_data[0]}, 0);
            break;
          end
        end
      end
      // execution writes, two per clock
      for (int h = 0; h < 2; h++) begin
        for (int p = 0; p < NWB; p++) begin
          wb_en[p]   = vmask[h * 2 + p];
          wb_idx[p]  = CIW'(base + h * 2 + p);
          wb_data[p] = val_of(v, h * 2 + p);
        end
        tick();
      end
      wb_en = '0;
      for (int l = 0; l < NLANE; l++) begin
        if (vmask[l]) begin
          look(1'b1, CIW'(base + l), 5'd0);
          chk(lk_src[0] == 2'd1 && lk_data[0] == val_of(v, l), "R3 done from commit file",
              {lk_src[0], lk_data[0]}, {2'd1, val_of(v, l)});
        end
      end
      // retire batch
      for (int l = 0; l < NLANE; l++) begin
        ret_valid[l] = vmask[l];
        ret_idx[l]   = CIW'(base + l);
        ret_dst[l]   = VEC[v][l*5 +: 5];
      end
      #1;
      chk(aw_en == exp_en, "R5 R10 youngest-only enables", 64'(aw_en), 64'(exp_en));
      for (int l = 0; l < NLANE; l++) begin
        if (exp_en[l]) begin
          chk(aw_addr[l] == ret_dst[l] && aw_data[l] == val_of(v, l), "R7 port address and data",
              {aw_addr[l], aw_data[l]}, {ret_dst[l], val_of(v, l)});
        end
        for (int m = l + 1; m < NLANE; m++) begin
          chk(!(aw_en[l] && aw_en[m] && aw_addr[l] == aw_addr[m]), "R6 distinct addresses",
              {aw_addr[l], aw_addr[m]}, 0);
        end
      end
      for (int l = 0; l < NLANE; l++) if (vmask[l]) arch_m[VEC[v][l*5 +: 5]] = val_of(v, l);
      tick();
      ret_valid = '0;
      for (int l = 0; l < NLANE; l++) begin
        if (vmask[l]) begin
          look(1'b0, 4'd0, VEC[v][l*5 +: 5]);
          chk(lk_data[0] == arch_m[VEC[v][l*5 +: 5]], "R4 R5 architectural value",
              64'(lk_data[0]), 64'(arch_m[VEC[v][l*5 +: 5]]));
          look(1'b1, CIW'(base + l), VEC[v][l*5 +: 5]);
          chk(lk_src[0] == 2'd2, "R4 R5 retired entry free", 64'(lk_src[0]), 2);
        end
      end
    end

    // R8: flush with a retiring lane in the same clock
    alloc_en = 1'b1; alloc_idx = 4'd5; tick();
    alloc_idx = 4'd6; tick();
    alloc_en = 1'b0;
    wb_en = 2'b01; wb_idx[0] = 4'd6; wb_data[0] = 32'hDEAD_BEEF; tick();
    wb_en = '0;
    flush = 1'b1;
    ret_valid = 4'b0001; ret_idx[0] = 4'd6; ret_dst[0] = 5'd3;
    alloc_en = 1'b1; alloc_idx = 4'd7;
    #1;
    chk(aw_en == '0, "R8 enables low during flush", 64'(aw_en), 0);
    tick();
    flush = 1'b0; ret_valid = '0; alloc_en = 1'b0;
    look(1'b1, 4'd5, 5'd3);
    chk(lk_src[0] == 2'd2, "R8 pending entry freed", 64'(lk_src[0]), 2);
    look(1'b1, 4'd7, 5'd3);
    chk(lk_src[0] == 2'd2, "R8 allocation ignored", 64'(lk_src[0]), 2);
    look(1'b1, 4'd6, 5'd3);
    chk(lk_src[0] == 2'd2 && lk_data[0] == arch_m[3], "R8 arch unchanged",
        {lk_src[0], lk_data[0]}, {2'd2, arch_m[3]});

    // R1: reset again returns everything to zero
    rst_n = 1'b0; tick(); rst_n = 1'b1;
    look(1'b0, 4'd0, 5'd5);
    chk(lk_data[0] == '0, "R1 arch cleared by reset", 64'(lk_data[0]), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule